// File: doc/BRIEF.md
# Serial Command Receiver for a Multiplexed Display

This block is the host-facing front end of a scanned display controller. A host drives three wires: a shift clock, a data line and a load strobe. Each word is 18 bits long and enters most significant bit first. The receiver runs entirely in the system clock domain. It brings the three wires through synchronisers and shifts a bit on each detected falling edge of the shift clock.

A holding register follows the shift register while the strobe is high. It freezes when the strobe drops. That falling edge also launches exactly one command. The command is decoded from the three top bits of the held word. It can do one of six things:
- write a segment pattern into a 16-entry display memory, at an auto-incrementing write address;
- set the static LED outputs;
- set the count of scanned digits;
- move the write address;
- set the brightness duty value;
- set a test-mode value.

The scan engine reads the display memory through a combinational read port. It also sees the memory write port and all register values directly.

Top module: `vfd_cmd_rx`

## Requirements
- R1: After reset the LED, digit-count, duty, test and write-address outputs are all zero, every display memory entry reads zero, and no write pulse appears.
- R2: The word is assembled most significant bit first, one bit per falling edge of the shift clock; a rising edge never moves the shift register.
- R3: While load is high the holding register follows the shift register and nothing executes; the word present when load falls executes exactly once.
- R4: A held word with bits 17 and 16 both zero writes bits 15..0 (bit 0 = segment A, bit 15 = segment P) into the display memory at the current write address, with a single one-cycle pulse on the write port.
- R5: After every display write the write address advances by one and wraps from 15 to 0, whatever the digit count holds.
- R6: Opcode 100 (bits 17..15) sets the LED outputs from bits 4..0, bit 0 driving LED 1; a 1 lights the LED.
- R7: Opcode 101 sets the digit-count register from bits 3..0.
- R8: Opcode 110 sets the write address from bits 3..0, and the next display write lands there (address 0 is digit 1, address 15 is digit 16).
- R9: Opcode 111 with bit 14 clear sets the duty register from bits 3..0; with bit 14 set it sets the test-mode register from bits 3..0 instead.
- R10: A word with bits 17..16 equal to 01 changes no register, no memory entry and the write address, and gives no write pulse.
- R11: When the load strobe and the shift clock fall together, the word executed is the one held before that shift, and the shifted bit joins the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdat_i | input | 1 | Serial data, MSB first |
| load_i | input | 1 | Load strobe, transparent while high |
| ram_we_o | output | 1 | Display memory write pulse |
| ram_waddr_o | output | 4 | Display memory write address |
| ram_wdata_o | output | 16 | Display memory write data, bit 0 = segment A |
| rd_addr_i | input | 4 | Scan-engine read address |
| rd_data_o | output | 16 | Scan-engine read data |
| waddr_o | output | 4 | Current write address counter |
| led_o | output | 5 | Static LED outputs |
| digits_o | output | 4 | Digit-count register |
| duty_o | output | 4 | Brightness duty register |
| test_o | output | 4 | Test-mode register |

## Verification
Shifting and command execution can fall into the same system cycle. This happens when the host drops the load strobe at the very instant it drops the shift clock. The bench provokes this on purpose. It drives both wires low in one step, so that the identical synchroniser paths report both edges together. It then checks two things. First, the LED value executed is the one held before the extra bit arrived. Second, a later strobe executes the word shifted by that bit, and the bench checks it against the memory write it predicts.

// File: rtl/vfd_cmd_pkg.sv
package vfd_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_DATA, CMD_LED, CMD_DIGIT, CMD_WADDR, CMD_DUTY, CMD_TEST
  } cmd_e;

  localparam logic [2:0] OP_LED   = 3'b100;
  localparam logic [2:0] OP_DIGIT = 3'b101;
  localparam logic [2:0] OP_WADDR = 3'b110;
  localparam logic [2:0] OP_MISC  = 3'b111;
endpackage

// File: rtl/vfd_sync.sv
module vfd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/vfd_frontend.sv
module vfd_frontend #(
  parameter int WORD_W = 18,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] word_o,
  output logic              exec_o
);
  logic sclk_s, sdat_s, load_s;
  logic sclk_q, load_q;
  logic sclk_fall, load_fall;
  logic [WORD_W-1:0] shreg_q, held_q;

  vfd_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdat_i, load_i}),
    .q_o   ({sclk_s, sdat_s, load_s})
  );

  assign sclk_fall = sclk_q & ~sclk_s;
  assign load_fall = load_q & ~load_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      load_q  <= 1'b0;
      shreg_q <= '0;
      held_q  <= '0;
    end else begin
      sclk_q <= sclk_s;
      load_q <= load_s;
      if (sclk_fall) shreg_q <= {shreg_q[WORD_W-2:0], sdat_s};
      // transparent while strobe high, frozen otherwise
      if (load_s)    held_q  <= shreg_q;
    end
  end

  assign word_o = held_q;
  assign exec_o = load_fall;

  p_shift_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(shreg_q));
  p_hold_when_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_s |=> $stable(held_q));
  p_exec_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);
endmodule

// File: rtl/vfd_decode.sv
module vfd_decode
  import vfd_cmd_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 4,
  parameter int LED_W  = 5,
  parameter int DUTY_W = 4,
  localparam int WORD_W = SEG_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              exec_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic [SEG_W-1:0]  ram_wdata_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [LED_W-1:0]  led_o,
  output logic [ADDR_W-1:0] digits_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [DUTY_W-1:0] test_o
);
  localparam int OP_LSB = WORD_W - 3;
  localparam int SEL_B  = WORD_W - 4;

  cmd_e cmd;
  logic [2:0] op;
  logic we_q;
  logic [ADDR_W-1:0] wa_q, waddr_q, dig_q;
  logic [SEG_W-1:0]  wd_q;
  logic [LED_W-1:0]  led_q;
  logic [DUTY_W-1:0] duty_q, test_q;

  assign op = word_i[WORD_W-1:OP_LSB];

  always_comb begin
    cmd = CMD_NONE;
    if (exec_i) begin
      if (op[2:1] == 2'b00) cmd = CMD_DATA;
      else begin
        case (op)
          OP_LED:   cmd = CMD_LED;
          OP_DIGIT: cmd = CMD_DIGIT;
          OP_WADDR: cmd = CMD_WADDR;
          OP_MISC:  cmd = word_i[SEL_B] ? CMD_TEST : CMD_DUTY;
          default:  cmd = CMD_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
      waddr_q <= '0;
      led_q   <= '0;
      dig_q   <= '0;
      duty_q  <= '0;
      test_q  <= '0;
    end else begin
      we_q <= (cmd == CMD_DATA);
      case (cmd)
        CMD_DATA: begin
          wa_q    <= waddr_q;
          wd_q    <= word_i[SEG_W-1:0];
          waddr_q <= waddr_q + ADDR_W'(1);
        end
        CMD_LED:   led_q   <= word_i[LED_W-1:0];
        CMD_DIGIT: dig_q   <= word_i[ADDR_W-1:0];
        CMD_WADDR: waddr_q <= word_i[ADDR_W-1:0];
        CMD_DUTY:  duty_q  <= word_i[DUTY_W-1:0];
        CMD_TEST:  test_q  <= word_i[DUTY_W-1:0];
        default: ;
      endcase
    end
  end

  assign ram_we_o    = we_q;
  assign ram_waddr_o = wa_q;
  assign ram_wdata_o = wd_q;
  assign waddr_o     = waddr_q;
  assign led_o       = led_q;
  assign digits_o    = dig_q;
  assign duty_o      = duty_q;
  assign test_o      = test_q;

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (waddr_q == ADDR_W'(wa_q + ADDR_W'(1))));
  p_led_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op == OP_LED) |=> led_q == $past(word_i[LED_W-1:0]));
  p_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op[2:1] == 2'b01) |=> (!we_q && $stable(waddr_q) && $stable(led_q)
      && $stable(dig_q) && $stable(duty_q) && $stable(test_q)));
  p_duty_test_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op == OP_MISC && !word_i[SEL_B]) |=> $stable(test_q));
endmodule

// File: rtl/vfd_seg_ram.sv
module vfd_seg_ram #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [SEG_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [SEG_W-1:0]  rdata_o
);
  logic [SEG_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  p_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 4,
  parameter int LED_W  = 5,
  parameter int DUTY_W = 4,
  parameter int SYNC_N = 2,
  localparam int WORD_W = SEG_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              load_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic [SEG_W-1:0]  ram_wdata_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [SEG_W-1:0]  rd_data_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [LED_W-1:0]  led_o,
  output logic [ADDR_W-1:0] digits_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [DUTY_W-1:0] test_o
);
  logic [WORD_W-1:0] word;
  logic exec;

  vfd_frontend #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_front (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_i(sclk_i),
    .sdat_i(sdat_i),
    .load_i(load_i),
    .word_o(word),
    .exec_o(exec)
  );

  vfd_decode #(.SEG_W(SEG_W), .ADDR_W(ADDR_W), .LED_W(LED_W), .DUTY_W(DUTY_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word),
    .exec_i     (exec),
    .ram_we_o   (ram_we_o),
    .ram_waddr_o(ram_waddr_o),
    .ram_wdata_o(ram_wdata_o),
    .waddr_o    (waddr_o),
    .led_o      (led_o),
    .digits_o   (digits_o),
    .duty_o     (duty_o),
    .test_o     (test_o)
  );

  vfd_seg_ram #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we_o),
    .waddr_i(ram_waddr_o),
    .wdata_i(ram_wdata_o),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: tb/sim_vfd_cmd_rx.sv
module sim_vfd_cmd_rx;
  logic clk = 1'b0;
  logic rst_n, sclk, sdat, load;
  logic [3:0] rd_addr;
  logic ram_we;
  logic [3:0] ram_waddr, waddr, digits, duty, test;
  logic [15:0] ram_wdata, rd_data;
  logic [4:0] led;

  int total = 0, bad = 0, we_cnt = 0;
  logic [4:0]  e_led = '0;
  logic [3:0]  e_dig = '0, e_duty = '0, e_test = '0, e_wa = '0;
  logic [15:0] e_mem [16];

  always #2 clk = ~clk;

  vfd_cmd_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat), .load_i(load),
    .ram_we_o(ram_we), .ram_waddr_o(ram_waddr), .ram_wdata_o(ram_wdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .waddr_o(waddr), .led_o(led),
    .digits_o(digits), .duty_o(duty), .test_o(test)
  );

  always @(posedge clk) if (rst_n && ram_we) we_cnt++;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic shift_word(logic [17:0] w);
    for (int i = 17; i >= 0; i--) begin
      sdat = w[i]; sclk = 1'b1; tick(4);
      sclk = 1'b0; tick(4);
    end
  endtask

  task automatic strobe();
    load = 1'b1; tick(6);
    load = 1'b0; tick(8);
  endtask

  task automatic send(logic [17:0] w);
    shift_word(w);
    strobe();
  endtask

  task automatic write_seg(logic [15:0] d);
    send({2'b00, d});
    e_mem[e_wa] = d;
    e_wa = e_wa + 4'd1;
  endtask

  task automatic check_regs(string tag);
    chk({tag, " led"}, led, e_led);
    chk({tag, " digits"}, digits, e_dig);
    chk({tag, " duty"}, duty, e_duty);
    chk({tag, " test"}, test, e_test);
    chk({tag, " waddr"}, waddr, e_wa);
  endtask

  task automatic check_mem(string tag);
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a); #1;
      chk(tag, rd_data, e_mem[a]);
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    logic [17:0] a_w, s_w;
    for (int i = 0; i < 16; i++) e_mem[i] = '0;
    rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; load = 1'b0; rd_addr = '0;
    tick(3); rst_n = 1'b1; tick(4);

    // R1 reset state
    check_regs("R1");
    check_mem("R1 mem");
    chk("R1 no write pulse", we_cnt, 0);

    // R7 digit count 3, then R4/R5 writes wrap past 16 regardless
    send({3'b101, 11'h5AA, 4'd3}); e_dig = 4'd3;
    check_regs("R7 digit");
    for (int i = 0; i < 18; i++) begin
      n0 = we_cnt;
      write_seg(16'((i * 16'h1111) ^ 16'hA5C3 ^ (i << 13)));
      chk("R4 one pulse", we_cnt - n0, 1);
      chk("R5 waddr wrap", waddr, e_wa);
    end
    check_mem("R4 mem contents");

    // R6 LED sweep with junk in unused payload bits, R2 MSB-first order
    for (int v = 0; v < 32; v++) begin
      send({3'b100, 10'(v * 37), 5'(v)}); e_led = 5'(v);
      chk("R6 R2 led", led, e_led);
    end

    // R7 digit sweep
    for (int v = 0; v < 16; v++) begin
      send({3'b101, 11'h7FF, 4'(v)}); e_dig = 4'(v);
      chk("R7 digits", digits, e_dig);
    end

    // R9 duty sweep (bit14 = 0) and test loads (bit14 = 1)
    for (int v = 0; v < 16; v++) begin
      send({3'b111, 1'b0, 10'h3FF, 4'(v)}); e_duty = 4'(v);
      chk("R9 duty", duty, e_duty);
      chk("R9 test unchanged", test, e_test);
    end
    for (int v = 1; v < 16; v += 5) begin
      send({3'b111, 1'b1, 10'h155, 4'(v)}); e_test = 4'(v);
      chk("R9 test", test, e_test);
      chk("R9 duty unchanged", duty, e_duty);
    end

    // R8 address load then write lands there
    for (int v = 0; v < 16; v++) begin
      send({3'b110, 11'h2A5, 4'(15 - v)}); e_wa = 4'(15 - v);
      chk("R8 waddr load", waddr, e_wa);
      write_seg(16'(16'hF00F ^ (v << 4)));
    end
    check_mem("R8 mem");

    // R10 opcode 01x ignored
    n0 = we_cnt;
    for (int v = 0; v < 6; v++) begin
      send({2'b01, 1'(v), 15'(v * 4321)});
      check_regs("R10 ignored");
    end
    chk("R10 no pulse", we_cnt - n0, 0);
    check_mem("R10 mem");

    // R3 word shifted while load high executes only at fall
    n0 = we_cnt;
    load = 1'b1; tick(6);
    shift_word({3'b100, 10'h0, 5'b01001});
    chk("R3 no exec while high", led, e_led);
    load = 1'b0; tick(8); e_led = 5'b01001;
    chk("R3 exec at fall", led, e_led);
    chk("R3 no write", we_cnt - n0, 0);

    // R2 rising edge alone does not shift
    send({3'b100, 10'h0, 5'b10001});
    sdat = 1'b1; sclk = 1'b1; tick(4);
    strobe(); e_led = 5'b10001;
    chk("R2 rise no shift", led, e_led);
    sclk = 1'b0; tick(4);   // this fall shifts a 1 in; next word overwrites

    // R11 load and shift clock fall in the same instant
    a_w = {3'b100, 10'h0, 5'b10110};
    shift_word(a_w);
    load = 1'b1; tick(6);
    sdat = 1'b1; sclk = 1'b1; tick(4);
    sclk = 1'b0; load = 1'b0; tick(8);
    e_led = 5'b10110;
    chk("R11 pre-shift word", led, e_led);
    n0 = we_cnt;
    s_w = {a_w[16:0], 1'b1};
    strobe();
    e_mem[e_wa] = s_w[15:0]; e_wa = e_wa + 4'd1;
    chk("R11 shifted word pulse", we_cnt - n0, 1);
    check_regs("R11 after");
    check_mem("R11 mem");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule